// File: doc/BRIEF.md
# UART Interrupt Priority Identification Logic

This block collects the five interrupt conditions of a 16550-class serial port and reports them to software. The five conditions are receiver line errors, received data ready, receive character timeout, transmit holding register empty, and modem line change. Each condition is held in a pending latch. Each source is masked by its own enable bit. The highest-priority pending source is encoded into a read-only identification byte, and all enabled pending sources are combined into a single registered interrupt line.

Each latch is cleared only by the register access that belongs to its source. Reading the identification byte clears the transmit-empty condition, but only when that condition is the one being reported. The identification byte is a combinational view of the registered latch state. The byte returned by a read is therefore the one from before the clear that the same read causes. The baud generator, shift registers, FIFOs and timeout counter are outside this block and appear only as input signals. Access strobes are single-cycle pulses from the register decoder.

The enable vector `ier` uses these bit positions:
- bit 0: received data ready and character timeout.
- bit 1: transmit holding register empty.
- bit 2: line errors.
- bit 3: modem change.

Top module: `uart_irq_ident`

## Requirements
- R1: Bit 0 of `iirData` is active low. It reads 0 while any enabled source is pending. It reads 1 when none is pending, and bits 3..0 are then 4'b0001. After reset `iirData` is 8'h01 when `fifoEn` is 0.
- R2: When a source is reported, bits 3..0 of `iirData` carry its code:
  - line errors: 4'b0110
  - data ready: 4'b0100
  - character timeout: 4'b1100
  - transmit empty: 4'b0010
  - modem change: 4'b0000
- R3: When several enabled sources are pending, the code reported follows this order:
  - line errors first;
  - data ready next, which wins over character timeout when both are pending;
  - character timeout, which shares the data-ready level;
  - transmit empty;
  - modem change last.
- R4: Any bit of `lineErr` sets the line-error latch. The latch clears on a `lsrRead` pulse. If a new error and the read fall in the same cycle, the latch stays set.
- R5: A rising edge of `rxAvail` sets the data-ready latch. The latch clears on a `rbrRead` pulse or when `rxAvail` falls.
- R6: A `rxTimeout` pulse sets the timeout latch only while `fifoEn` is 1. The latch clears on `rbrRead` or when `fifoEn` is 0.
- R7: The transmit-empty latch is set by a rising edge of `thrEmpty`. It is also set when `ier` bit 1 rises while `thrEmpty` is 1. A `thrWrite` pulse clears it.
- R8: An `iirRead` pulse clears the transmit-empty latch only when transmit empty is the source being reported in that cycle. Otherwise the latch is kept.
- R9: Any bit of `modemDelta` sets the modem latch. The latch clears on a `msrRead` pulse.
- R10: A source whose enable bit is 0 does not appear in `iirData` and does not assert `irqOut`. Its latch keeps its value and is reported once the bit is set again.
- R11: Bits 6..4 of `iirData` read 0 and bit 7 equals `fifoEn`. Bit 3 is 0 whenever `fifoEn` is 0.
- R12: `irqOut` rises one clock after `iirData` bit 0 goes to 0, and falls one clock after it returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineErr | input | LINE_W | Line error pulses (overrun, parity, framing, break) |
| rxAvail | input | 1 | Receive data ready, or FIFO fill level at or above the trigger level |
| rxTimeout | input | 1 | Pulse from the character timeout counter |
| thrEmpty | input | 1 | Transmit holding register empty status |
| modemDelta | input | MODEM_W | Change pulses for the CTS, DSR, RI and DCD modem lines |
| ier | input | 4 | Per-source enable bits |
| fifoEn | input | 1 | FIFO mode enable |
| rbrRead | input | 1 | Receive buffer read strobe |
| thrWrite | input | 1 | Transmit holding register write strobe |
| iirRead | input | 1 | Identification register read strobe |
| lsrRead | input | 1 | Line status register read strobe |
| msrRead | input | 1 | Modem status register read strobe |
| iirData | output | 8 | Identification byte |
| irqOut | output | 1 | Registered interrupt request |

## Verification
The assertions check the properties that hold in every cycle:
- bits 6..4 of the identification byte stay at zero;
- bit 3 is clear outside FIFO mode;
- an enabled line error is reported with its code in the next cycle;
- a modem-status read with no new change leaves the modem latch cleared;
- `irqOut` follows the pending flag with exactly one cycle of lag.

Other behaviour can only be shown by the bench's directed scenarios. These cover the full priority order and the data-ready-over-timeout rule at the shared level. They also cover the conditional clear of transmit empty on an identification read and the re-arm on the enable bit. Finally, they cover the retention of masked conditions and the rule that a set wins over a coincident clear.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  // Source index, listed from highest to lowest priority
  typedef enum logic [2:0] {
    SRC_LINE    = 3'd0,
    SRC_RXDATA  = 3'd1,
    SRC_TIMEOUT = 3'd2,
    SRC_THR     = 3'd3,
    SRC_MODEM   = 3'd4,
    SRC_NONE    = 3'd7
  } srcSel_t;

  localparam int NUM_SRC = 5;

  // Strobes from control to datapath
  typedef struct packed {
    logic clrLine;
    logic clrRx;
    logic clrTmo;
    logic clrThr;
    logic clrModem;
    logic armThr;
  } clrStrobes_t;

  function automatic logic [3:0] srcCode(srcSel_t s);
    case (s)
      SRC_LINE:    srcCode = 4'b0110;
      SRC_RXDATA:  srcCode = 4'b0100;
      SRC_TIMEOUT: srcCode = 4'b1100;
      SRC_THR:     srcCode = 4'b0010;
      SRC_MODEM:   srcCode = 4'b0000;
      default:     srcCode = 4'b0001;
    endcase
  endfunction

endpackage

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
  import uirq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rbrRead,
  input  logic        thrWrite,
  input  logic        iirRead,
  input  logic        lsrRead,
  input  logic        msrRead,
  input  logic        fifoEn,
  input  logic        thrEnable,
  input  logic        thrEmpty,
  input  srcSel_t     reported,
  output clrStrobes_t strb
);

  logic thrEnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) thrEnQ <= 1'b0;
    else       thrEnQ <= thrEnable;
  end

  always_comb begin
    strb.clrLine  = lsrRead;
    strb.clrRx    = rbrRead;
    strb.clrTmo   = rbrRead | ~fifoEn;
    strb.clrModem = msrRead;
    // The identification read clears transmit empty only while it is the reported source
    strb.clrThr   = thrWrite | (iirRead && (reported == SRC_THR));
    // A rising enable bit re-arms transmit empty when the holding register is already empty
    strb.armThr   = thrEnable & ~thrEnQ & thrEmpty;
  end

  // R8: an identification read while another source is reported does not clear transmit empty
  thr_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (iirRead && !thrWrite && reported != SRC_THR) |-> !strb.clrThr);

endmodule

// File: rtl/uirq_datapath.sv
module uirq_datapath
  import uirq_pkg::*;
#(
  parameter int LINE_W  = 4,
  parameter int MODEM_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LINE_W-1:0]  lineErr,
  input  logic               rxAvail,
  input  logic               rxTimeout,
  input  logic               thrEmpty,
  input  logic [MODEM_W-1:0] modemDelta,
  input  logic [3:0]         ier,
  input  logic               fifoEn,
  input  logic               msrRead,
  input  clrStrobes_t        strb,
  output srcSel_t            reported,
  output logic [7:0]         iirData,
  output logic               irqOut
);

  logic               rxAvailQ;
  logic               thrEmptyQ;
  logic               irqQ;
  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] clrVec;
  logic [NUM_SRC-1:0] pendVec;
  logic [NUM_SRC-1:0] enVec;
  logic [NUM_SRC-1:0] activeVec;
  logic [3:0]         code;

  // Edge detectors on the level inputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxAvailQ  <= 1'b0;
      thrEmptyQ <= 1'b1;
    end else begin
      rxAvailQ  <= rxAvail;
      thrEmptyQ <= thrEmpty;
    end
  end

  always_comb begin
    setVec[SRC_LINE]    = |lineErr;
    setVec[SRC_RXDATA]  = rxAvail & ~rxAvailQ;
    setVec[SRC_TIMEOUT] = rxTimeout & fifoEn;
    setVec[SRC_THR]     = (thrEmpty & ~thrEmptyQ) | strb.armThr;
    setVec[SRC_MODEM]   = |modemDelta;

    clrVec[SRC_LINE]    = strb.clrLine;
    clrVec[SRC_RXDATA]  = strb.clrRx | ~rxAvail;
    clrVec[SRC_TIMEOUT] = strb.clrTmo;
    clrVec[SRC_THR]     = strb.clrThr;
    clrVec[SRC_MODEM]   = strb.clrModem;

    enVec[SRC_LINE]     = ier[2];
    enVec[SRC_RXDATA]   = ier[0];
    enVec[SRC_TIMEOUT]  = ier[0] & fifoEn;
    enVec[SRC_THR]      = ier[1];
    enVec[SRC_MODEM]    = ier[3];
  end

  // One pending latch per source; a set wins over a coincident clear
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_latch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          pendVec[s] <= 1'b0;
      else if (setVec[s]) pendVec[s] <= 1'b1;
      else if (clrVec[s]) pendVec[s] <= 1'b0;
    end
  end

  assign activeVec = pendVec & enVec;

  // Priority pick: the lowest index wins
  always_comb begin
    reported = SRC_NONE;
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (activeVec[s]) reported = srcSel_t'(s);
    end
  end

  assign code    = srcCode(reported);
  assign iirData = {fifoEn, 3'b000, code};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= |activeVec;
  end
  assign irqOut = irqQ;

  // R11: bits 6..4 of the identification byte stay zero
  unused_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    iirData[6:4] == 3'b000);

  // R11: no timeout code outside FIFO mode
  char_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn |-> !iirData[3]);

  // R4: an enabled line error is reported in the next cycle
  line_report_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((|lineErr) && ier[2]) |=> (iirData[3:0] == 4'b0110));

  // R9: a modem status read with no new change empties the modem latch
  modem_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msrRead && !(|modemDelta)) |=> !pendVec[SRC_MODEM]);

  // R12: the request line follows the pending flag one cycle later
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    !iirData[0] |=> irqOut);

  // R12
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    iirData[0] |=> !irqOut);

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uirq_pkg::*;
#(
  parameter int LINE_W  = 4,
  parameter int MODEM_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [LINE_W-1:0]  lineErr,
  input  logic               rxAvail,
  input  logic               rxTimeout,
  input  logic               thrEmpty,
  input  logic [MODEM_W-1:0] modemDelta,
  input  logic [3:0]         ier,
  input  logic               fifoEn,
  input  logic               rbrRead,
  input  logic               thrWrite,
  input  logic               iirRead,
  input  logic               lsrRead,
  input  logic               msrRead,
  output logic [7:0]         iirData,
  output logic               irqOut
);

  clrStrobes_t strb;
  srcSel_t     reported;

  uirq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .rbrRead   (rbrRead),
    .thrWrite  (thrWrite),
    .iirRead   (iirRead),
    .lsrRead   (lsrRead),
    .msrRead   (msrRead),
    .fifoEn    (fifoEn),
    .thrEnable (ier[1]),
    .thrEmpty  (thrEmpty),
    .reported  (reported),
    .strb      (strb)
  );

  uirq_datapath #(
    .LINE_W  (LINE_W),
    .MODEM_W (MODEM_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .lineErr    (lineErr),
    .rxAvail    (rxAvail),
    .rxTimeout  (rxTimeout),
    .thrEmpty   (thrEmpty),
    .modemDelta (modemDelta),
    .ier        (ier),
    .fifoEn     (fifoEn),
    .msrRead    (msrRead),
    .strb       (strb),
    .reported   (reported),
    .iirData    (iirData),
    .irqOut     (irqOut)
  );

endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] lineErr = '0;
  logic       rxAvail = 1'b0;
  logic       rxTimeout = 1'b0;
  logic       thrEmpty = 1'b0;
  logic [3:0] modemDelta = '0;
  logic [3:0] ier = '0;
  logic       fifoEn = 1'b0;
  logic       rbrRead = 1'b0;
  logic       thrWrite = 1'b0;
  logic       iirRead = 1'b0;
  logic       lsrRead = 1'b0;
  logic       msrRead = 1'b0;
  logic [7:0] iirData;
  logic       irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk(clk), .rstN(rstN), .lineErr(lineErr), .rxAvail(rxAvail),
    .rxTimeout(rxTimeout), .thrEmpty(thrEmpty), .modemDelta(modemDelta),
    .ier(ier), .fifoEn(fifoEn), .rbrRead(rbrRead), .thrWrite(thrWrite),
    .iirRead(iirRead), .lsrRead(lsrRead), .msrRead(msrRead),
    .iirData(iirData), .irqOut(irqOut)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 reset id", iirData, 8'h01);
    chk("R12 reset irq", {7'd0, irqOut}, 8'h00);
  endtask

  task automatic t_line();
    ier = 4'b0100;
    lineErr = 4'b0010; step(); lineErr = '0;
    chk("R2/R4 line code", iirData, 8'h06);
    step();
    chk("R12 irq up", {7'd0, irqOut}, 8'h01);
    lineErr = 4'b1000; lsrRead = 1'b1; step(); lineErr = '0; lsrRead = 1'b0;
    chk("R4 set beats clear", iirData, 8'h06);
    lsrRead = 1'b1; step(); lsrRead = 1'b0;
    chk("R4 lsr clear", iirData, 8'h01);
    step();
    chk("R12 irq down", {7'd0, irqOut}, 8'h00);
  endtask

  task automatic t_modem();
    ier = 4'b1000;
    modemDelta = 4'b0100; step(); modemDelta = '0;
    chk("R9 modem code", iirData, 8'h00);
    msrRead = 1'b1; step(); msrRead = 1'b0;
    chk("R9 msr clear", iirData, 8'h01);
  endtask

  task automatic t_rx();
    ier = 4'b0001;
    rxAvail = 1'b1; step();
    chk("R5 data ready code", iirData, 8'h04);
    rbrRead = 1'b1; step(); rbrRead = 1'b0;
    chk("R5 rbr clear", iirData, 8'h01);
    rxAvail = 1'b0; step();
    rxAvail = 1'b1; step();
    chk("R5 rearm", iirData, 8'h04);
    rxAvail = 1'b0; step();
    chk("R5 level fall clear", iirData, 8'h01);
  endtask

  task automatic t_timeout();
    ier = 4'b0001; fifoEn = 1'b1; step();
    chk("R11 fifo bit", iirData, 8'h81);
    rxTimeout = 1'b1; step(); rxTimeout = 1'b0;
    chk("R6 timeout code", iirData, 8'h8C);
    rbrRead = 1'b1; step(); rbrRead = 1'b0;
    chk("R6 rbr clear", iirData, 8'h81);
    fifoEn = 1'b0; step();
    rxTimeout = 1'b1; step(); rxTimeout = 1'b0;
    chk("R6/R11 ignored in char mode", iirData, 8'h01);
  endtask

  task automatic t_thr();
    ier = 4'b0010;
    thrEmpty = 1'b1; step();
    chk("R7 thr code", iirData, 8'h02);
    thrWrite = 1'b1; thrEmpty = 1'b0; step(); thrWrite = 1'b0;
    chk("R7 write clear", iirData, 8'h01);
    thrEmpty = 1'b1; step();
    chk("R7 edge rearm", iirData, 8'h02);
    iirRead = 1'b1; step(); iirRead = 1'b0;
    chk("R8 id read clear", iirData, 8'h01);
    ier = 4'b0000; step();
    ier = 4'b0010; step();
    chk("R7 enable rearm", iirData, 8'h02);
  endtask

  task automatic t_thr_hidden();
    ier = 4'b0110;
    lineErr = 4'b0001; step(); lineErr = '0;
    chk("R3 line over thr", iirData, 8'h06);
    iirRead = 1'b1; step(); iirRead = 1'b0;
    chk("R8 read while line shown", iirData, 8'h06);
    lsrRead = 1'b1; step(); lsrRead = 1'b0;
    chk("R8 thr kept", iirData, 8'h02);
    iirRead = 1'b1; step(); iirRead = 1'b0;
    chk("R8 thr cleared", iirData, 8'h01);
  endtask

  task automatic t_priority();
    ier = 4'b1111; fifoEn = 1'b1;
    thrEmpty = 1'b0; step();
    thrEmpty = 1'b1; modemDelta = 4'b0001; rxAvail = 1'b1; rxTimeout = 1'b1; lineErr = 4'b0100;
    step();
    modemDelta = '0; rxTimeout = 1'b0; lineErr = '0;
    chk("R3 all line", iirData, 8'h86);
    lsrRead = 1'b1; step(); lsrRead = 1'b0;
    chk("R3 data before timeout", iirData, 8'h84);
    rxAvail = 1'b0; step();
    chk("R3 timeout next", iirData, 8'h8C);
    rbrRead = 1'b1; step(); rbrRead = 1'b0;
    chk("R3 thr next", iirData, 8'h82);
    iirRead = 1'b1; step(); iirRead = 1'b0;
    chk("R3 modem last", iirData, 8'h80);
    msrRead = 1'b1; step(); msrRead = 1'b0;
    chk("R1 all clear", iirData, 8'h81);
    fifoEn = 1'b0;
  endtask

  task automatic t_mask();
    ier = 4'b0000;
    lineErr = 4'b0001; step(); lineErr = '0;
    chk("R10 masked id", iirData, 8'h01);
    step();
    chk("R10 masked irq", {7'd0, irqOut}, 8'h00);
    ier = 4'b0100; step();
    chk("R10 retained", iirData, 8'h06);
    lsrRead = 1'b1; step(); lsrRead = 1'b0;
    chk("R4 final clear", iirData, 8'h01);
  endtask

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    t_reset();
    t_line();
    t_modem();
    t_rx();
    t_timeout();
    t_thr();
    t_thr_hidden();
    t_priority();
    t_mask();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule